// File: doc/BRIEF.md
# Shared Transmit/Receive Packet Buffer Controller

This block keeps a 128-byte single-port store that the radio's transmit path and receive path share in turn, and that a host reaches through a byte-serial register port. The host loads an outgoing frame by writing its length byte at address 0 and the payload after it. The transmit reader then fetches bytes by index. A received frame is written into the same store. Its length goes to a separate register, which the host reads to learn how many bytes to fetch, and a link-quality byte is placed just after the last payload byte.

The host moves data one byte at a time at an address it gives, or as a burst. A burst starts at a given address and then steps by one on each access, wrapping from 127 back to 0. The radio side always takes priority for the single RAM port. A host access that collides with a radio access is held off through a ready signal. A protect input stops incoming frames from overwriting the store but leaves host writes working. A sticky underrun interrupt reports a transmit read past the loaded frame.

Top module: `pktbuf_ctrl`

## Requirements
- R1: After reset `underrun_irq`, `host_rvalid` and `tx_rvalid` are 0, and `rx_frame_len` is 0.
- R2: When `host_first` is 1 or `host_burst` is 0, a granted host access (`host_req` and `host_ready`) uses address `host_addr`. A write (`host_wr`=1) stores `host_wdata` there.
- R3: In burst mode (`host_burst`=1, `host_first`=0), a granted host access uses the address one above that of the previous granted host access, wrapping from 127 to 0.
- R4: A granted host write to address 0 loads the transmit frame length. A transmit read (`tx_rd_req`) returns the byte stored at `tx_rd_addr`.
- R5: When `rx_protect` is 0, `rx_start` copies `rx_len_in` into `rx_frame_len` by the next cycle and sets the receive write index to 1. Each `rx_byte_valid` then stores `rx_byte` at that index and advances the index by one.
- R6: When `rx_protect` is 0, `rx_lqi_valid` stores `rx_lqi` at address `rx_frame_len` + 1, modulo 128.
- R7: While `rx_protect` is 1, receive bytes, quality bytes and `rx_start` change neither the store nor `rx_frame_len`, and a host write still completes.
- R8: A receive write that is not blocked, or a transmit read, wins the RAM port. `host_ready` is then 0 in that cycle, and the held host access completes in the next free cycle.
- R9: A transmit read with `tx_rd_addr` greater than the loaded transmit frame length sets `underrun_irq`. Reads at indexes 1 to that length do not. The flag stays set until cleared.
- R10: An `irq_clr` pulse clears `underrun_irq` on the next cycle. If a new underrun happens in the same cycle, the flag stays set.
- R11: Read data arrives one cycle after the grant. `host_rvalid` (or `tx_rvalid`) is 1 exactly in the cycle after a granted host read (or a transmit read), with the data on `host_rdata` (or `tx_rdata`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_req | input | 1 | Host access request |
| host_wr | input | 1 | 1 = host write, 0 = host read |
| host_burst | input | 1 | 1 = burst addressing, 0 = single-byte addressing |
| host_first | input | 1 | First access of a burst: address taken from host_addr |
| host_addr | input | 7 | Host byte address |
| host_wdata | input | 8 | Host write data |
| host_ready | output | 1 | Host access granted this cycle |
| host_rdata | output | 8 | Host read data |
| host_rvalid | output | 1 | host_rdata valid |
| tx_rd_req | input | 1 | Transmit reader byte request |
| tx_rd_addr | input | 7 | Transmit byte index |
| tx_rdata | output | 8 | Transmit read data |
| tx_rvalid | output | 1 | tx_rdata valid |
| rx_start | input | 1 | Start of a received frame |
| rx_len_in | input | 8 | Length of the received frame |
| rx_byte_valid | input | 1 | Received payload byte strobe |
| rx_byte | input | 8 | Received payload byte |
| rx_lqi_valid | input | 1 | Link-quality byte strobe |
| rx_lqi | input | 8 | Link-quality byte |
| rx_protect | input | 1 | Block receive writes into the store |
| rx_frame_len | output | 8 | Received frame length register |
| irq_clr | input | 1 | Write-one clear of the underrun flag |
| underrun_irq | output | 1 | Sticky underrun interrupt |

## Verification
A wrong receive index or a wrong quality-byte address leaves bytes at the wrong places. This shows up in the first host read of those addresses, one cycle after the grant. A wrong burst counter returns the wrong byte on the very next burst access, and the wrap from 127 to 0 is checked directly. A wrong transmit length shadow appears as a missing or a spurious `underrun_irq` in the cycle after the offending read. A broken arbiter shows up as `host_ready` high while the radio holds the port, or as a host write that is lost, which a later read finds.

// File: rtl/pktbuf_pkg.sv
package pktbuf_pkg;
  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_HOST = 2'd1,
    OWN_TX   = 2'd2,
    OWN_RX   = 2'd3
  } port_owner_e;
endpackage

// File: rtl/pktbuf_ram.sv
module pktbuf_ram #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) begin
        mem[addr] <= wdata;
      end else begin
        rdata <= mem[addr];
      end
    end
  end
endmodule

// File: rtl/pktbuf_arb.sv
module pktbuf_arb
  import pktbuf_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_wr_req,
  input  logic [AW-1:0] rx_addr,
  input  logic [DW-1:0] rx_data,
  input  logic          tx_rd_req,
  input  logic [AW-1:0] tx_addr,
  input  logic          host_req,
  input  logic          host_wr,
  input  logic          host_burst,
  input  logic          host_first,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic          host_ready,
  output logic [AW-1:0] host_acc_addr,
  output logic          host_rvalid,
  output logic          tx_rvalid,
  output logic          ram_en,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata
);
  port_owner_e   owner;
  logic [AW-1:0] burst_ptr_q, burst_ptr_d;
  logic          host_fire;
  logic          host_rvalid_d, tx_rvalid_d;

  // host address: burst continuation or given address
  always_comb begin
    if (host_burst && !host_first) begin
      host_acc_addr = burst_ptr_q;
    end else begin
      host_acc_addr = host_addr;
    end
  end

  // port priority: receive write, then transmit read, then host
  always_comb begin
    owner      = OWN_NONE;
    ram_en     = 1'b0;
    ram_we     = 1'b0;
    ram_addr   = '0;
    ram_wdata  = '0;
    host_ready = 1'b0;
    if (rx_wr_req) begin
      owner     = OWN_RX;
      ram_en    = 1'b1;
      ram_we    = 1'b1;
      ram_addr  = rx_addr;
      ram_wdata = rx_data;
    end else if (tx_rd_req) begin
      owner    = OWN_TX;
      ram_en   = 1'b1;
      ram_addr = tx_addr;
    end else if (host_req) begin
      owner      = OWN_HOST;
      host_ready = 1'b1;
      ram_en     = 1'b1;
      ram_we     = host_wr;
      ram_addr   = host_acc_addr;
      ram_wdata  = host_wdata;
    end
  end

  assign host_fire = host_req && host_ready;

  always_comb begin
    burst_ptr_d   = burst_ptr_q;
    if (host_fire) begin
      burst_ptr_d = host_acc_addr + AW'(1);
    end
    host_rvalid_d = (owner == OWN_HOST) && !host_wr;
    tx_rvalid_d   = (owner == OWN_TX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_ptr_q <= '0;
      host_rvalid <= 1'b0;
      tx_rvalid   <= 1'b0;
    end else begin
      if (host_fire) begin
        burst_ptr_q <= burst_ptr_d;
      end
      host_rvalid <= host_rvalid_d;
      tx_rvalid   <= tx_rvalid_d;
    end
  end
endmodule

// File: rtl/pktbuf_rxctl.sv
module pktbuf_rxctl #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_start,
  input  logic [DW-1:0] rx_len_in,
  input  logic          rx_byte_valid,
  input  logic [DW-1:0] rx_byte,
  input  logic          rx_lqi_valid,
  input  logic [DW-1:0] rx_lqi,
  input  logic          rx_protect,
  output logic          wr_req,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic [DW-1:0] frame_len
);
  logic [AW-1:0] idx_q, idx_d;
  logic [DW-1:0] len_d;
  logic [AW-1:0] lqi_addr;
  logic          idx_en, len_en;

  assign lqi_addr = frame_len[AW-1:0] + AW'(1);

  always_comb begin
    wr_req  = !rx_protect && (rx_byte_valid || rx_lqi_valid);
    wr_addr = rx_byte_valid ? idx_q : lqi_addr;
    wr_data = rx_byte_valid ? rx_byte : rx_lqi;
  end

  always_comb begin
    idx_en = rx_start || rx_byte_valid;
    idx_d  = rx_start ? AW'(1) : idx_q + AW'(1);
    len_en = rx_start && !rx_protect;
    len_d  = rx_len_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q     <= AW'(1);
      frame_len <= '0;
    end else begin
      if (idx_en) begin
        idx_q <= idx_d;
      end
      if (len_en) begin
        frame_len <= len_d;
      end
    end
  end
endmodule

// File: rtl/pktbuf_txmon.sv
module pktbuf_txmon #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          len_load,
  input  logic [DW-1:0] len_in,
  input  logic          tx_rd_req,
  input  logic [AW-1:0] tx_rd_addr,
  input  logic          irq_clr,
  output logic          underrun_irq
);
  logic [DW-1:0] len_q;
  logic          past_end;
  logic          irq_d;

  always_comb begin
    past_end = tx_rd_req && ({{(DW-AW){1'b0}}, tx_rd_addr} > len_q);
    irq_d    = past_end || (underrun_irq && !irq_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q        <= '0;
      underrun_irq <= 1'b0;
    end else begin
      if (len_load) begin
        len_q <= len_in;
      end
      underrun_irq <= irq_d;
    end
  end
endmodule

// File: rtl/pktbuf_ctrl.sv
module pktbuf_ctrl #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_req,
  input  logic          host_wr,
  input  logic          host_burst,
  input  logic          host_first,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic          host_ready,
  output logic [DW-1:0] host_rdata,
  output logic          host_rvalid,
  input  logic          tx_rd_req,
  input  logic [AW-1:0] tx_rd_addr,
  output logic [DW-1:0] tx_rdata,
  output logic          tx_rvalid,
  input  logic          rx_start,
  input  logic [DW-1:0] rx_len_in,
  input  logic          rx_byte_valid,
  input  logic [DW-1:0] rx_byte,
  input  logic          rx_lqi_valid,
  input  logic [DW-1:0] rx_lqi,
  input  logic          rx_protect,
  output logic [DW-1:0] rx_frame_len,
  input  logic          irq_clr,
  output logic          underrun_irq
);
  logic [1:0]    rst_pipe_q;
  logic          rst_n_int;
  logic          rx_wr_req;
  logic [AW-1:0] rx_wr_addr;
  logic [DW-1:0] rx_wr_data;
  logic [AW-1:0] host_acc_addr;
  logic          ram_en, ram_we;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_wdata, ram_rdata;
  logic          tx_len_load;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_n_int = rst_pipe_q[1];

  pktbuf_rxctl #(.DEPTH(DEPTH), .DW(DW)) u_rxctl (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .rx_start     (rx_start),
    .rx_len_in    (rx_len_in),
    .rx_byte_valid(rx_byte_valid),
    .rx_byte      (rx_byte),
    .rx_lqi_valid (rx_lqi_valid),
    .rx_lqi       (rx_lqi),
    .rx_protect   (rx_protect),
    .wr_req       (rx_wr_req),
    .wr_addr      (rx_wr_addr),
    .wr_data      (rx_wr_data),
    .frame_len    (rx_frame_len)
  );

  pktbuf_arb #(.DEPTH(DEPTH), .DW(DW)) u_arb (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .rx_wr_req    (rx_wr_req),
    .rx_addr      (rx_wr_addr),
    .rx_data      (rx_wr_data),
    .tx_rd_req    (tx_rd_req),
    .tx_addr      (tx_rd_addr),
    .host_req     (host_req),
    .host_wr      (host_wr),
    .host_burst   (host_burst),
    .host_first   (host_first),
    .host_addr    (host_addr),
    .host_wdata   (host_wdata),
    .host_ready   (host_ready),
    .host_acc_addr(host_acc_addr),
    .host_rvalid  (host_rvalid),
    .tx_rvalid    (tx_rvalid),
    .ram_en       (ram_en),
    .ram_we       (ram_we),
    .ram_addr     (ram_addr),
    .ram_wdata    (ram_wdata)
  );

  pktbuf_ram #(.DEPTH(DEPTH), .DW(DW)) u_ram (
    .clk  (clk),
    .en   (ram_en),
    .we   (ram_we),
    .addr (ram_addr),
    .wdata(ram_wdata),
    .rdata(ram_rdata)
  );

  assign host_rdata  = ram_rdata;
  assign tx_rdata    = ram_rdata;
  assign tx_len_load = host_req && host_ready && host_wr && (host_acc_addr == '0);

  pktbuf_txmon #(.DEPTH(DEPTH), .DW(DW)) u_txmon (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .len_load    (tx_len_load),
    .len_in      (host_wdata),
    .tx_rd_req   (tx_rd_req),
    .tx_rd_addr  (tx_rd_addr),
    .irq_clr     (irq_clr),
    .underrun_irq(underrun_irq)
  );
endmodule

// File: rtl/pktbuf_ctrl_chk.sv
module pktbuf_ctrl_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n_int,
  input logic          host_req,
  input logic          host_wr,
  input logic          host_ready,
  input logic          host_rvalid,
  input logic          tx_rd_req,
  input logic          tx_rvalid,
  input logic          rx_start,
  input logic [DW-1:0] rx_len_in,
  input logic          rx_byte_valid,
  input logic          rx_protect,
  input logic [DW-1:0] rx_frame_len,
  input logic          irq_clr,
  input logic          underrun_irq
);
  a_r8_radio_wins: assert property (@(posedge clk) disable iff (!rst_n_int)
    ((rx_byte_valid && !rx_protect) || tx_rd_req) |-> !host_ready);

  a_r11_host_rvalid: assert property (@(posedge clk) disable iff (!rst_n_int)
    (host_req && host_ready && !host_wr) |=> host_rvalid);

  a_r11_no_stray_rvalid: assert property (@(posedge clk) disable iff (!rst_n_int)
    !(host_req && host_ready && !host_wr) |=> !host_rvalid);

  a_r11_tx_rvalid: assert property (@(posedge clk) disable iff (!rst_n_int)
    tx_rd_req |=> tx_rvalid);

  a_r5_len_capture: assert property (@(posedge clk) disable iff (!rst_n_int)
    (rx_start && !rx_protect) |=> (rx_frame_len == $past(rx_len_in)));

  a_r7_len_hold: assert property (@(posedge clk) disable iff (!rst_n_int)
    (rx_start && rx_protect) |=> $stable(rx_frame_len));

  a_r9_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n_int)
    (underrun_irq && !irq_clr) |=> underrun_irq);

  a_r10_irq_clear: assert property (@(posedge clk) disable iff (!rst_n_int)
    (irq_clr && !tx_rd_req) |=> !underrun_irq);
endmodule

bind pktbuf_ctrl pktbuf_ctrl_chk #(.DW(DW)) u_chk (
  .clk          (clk),
  .rst_n_int    (rst_n_int),
  .host_req     (host_req),
  .host_wr      (host_wr),
  .host_ready   (host_ready),
  .host_rvalid  (host_rvalid),
  .tx_rd_req    (tx_rd_req),
  .tx_rvalid    (tx_rvalid),
  .rx_start     (rx_start),
  .rx_len_in    (rx_len_in),
  .rx_byte_valid(rx_byte_valid),
  .rx_protect   (rx_protect),
  .rx_frame_len (rx_frame_len),
  .irq_clr      (irq_clr),
  .underrun_irq (underrun_irq)
);

// File: tb/pktbuf_ctrl_tb.sv
`timescale 1ns/1ps
module pktbuf_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_req = 0, host_wr = 0, host_burst = 0, host_first = 0;
  logic [6:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic       host_ready, host_rvalid;
  logic [7:0] host_rdata;
  logic       tx_rd_req = 0;
  logic [6:0] tx_rd_addr = '0;
  logic [7:0] tx_rdata;
  logic       tx_rvalid;
  logic       rx_start = 0, rx_byte_valid = 0, rx_lqi_valid = 0, rx_protect = 0;
  logic [7:0] rx_len_in = '0, rx_byte = '0, rx_lqi = '0;
  logic [7:0] rx_frame_len;
  logic       irq_clr = 0;
  logic       underrun_irq;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  pktbuf_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .host_req(host_req), .host_wr(host_wr), .host_burst(host_burst),
    .host_first(host_first), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_ready(host_ready), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .tx_rd_req(tx_rd_req), .tx_rd_addr(tx_rd_addr), .tx_rdata(tx_rdata),
    .tx_rvalid(tx_rvalid), .rx_start(rx_start), .rx_len_in(rx_len_in),
    .rx_byte_valid(rx_byte_valid), .rx_byte(rx_byte), .rx_lqi_valid(rx_lqi_valid),
    .rx_lqi(rx_lqi), .rx_protect(rx_protect), .rx_frame_len(rx_frame_len),
    .irq_clr(irq_clr), .underrun_irq(underrun_irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic host_op(input logic wr, input logic burst, input logic first,
                         input logic [6:0] addr, input logic [7:0] wd,
                         output logic [7:0] rd, output logic rv);
    @(negedge clk);
    host_req = 1; host_wr = wr; host_burst = burst; host_first = first;
    host_addr = addr; host_wdata = wd;
    #1;
    while (!host_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    rd = host_rdata; rv = host_rvalid;
    host_req = 0; host_wr = 0;
  endtask

  task automatic hwrite(input logic [6:0] addr, input logic [7:0] d);
    logic [7:0] rd; logic rv;
    host_op(1'b1, 1'b0, 1'b0, addr, d, rd, rv);
  endtask

  task automatic hread_chk(input logic [6:0] addr, input logic [7:0] exp, input string req);
    logic [7:0] rd; logic rv;
    host_op(1'b0, 1'b0, 1'b0, addr, 8'h00, rd, rv);
    check(rv === 1'b1, {req, " host_rvalid"}, int'(rv), 1);
    check(rd === exp, req, int'(rd), int'(exp));
  endtask

  task automatic tx_read(input logic [6:0] idx, output logic [7:0] d);
    @(negedge clk);
    tx_rd_req = 1; tx_rd_addr = idx;
    @(negedge clk);
    tx_rd_req = 0;
    check(tx_rvalid === 1'b1, "R11 tx_rvalid", int'(tx_rvalid), 1);
    d = tx_rdata;
  endtask

  task automatic rx_begin(input logic [7:0] len);
    @(negedge clk); rx_start = 1; rx_len_in = len;
    @(negedge clk); rx_start = 0;
  endtask

  task automatic rx_push(input logic [7:0] b);
    @(negedge clk); rx_byte_valid = 1; rx_byte = b;
    @(negedge clk); rx_byte_valid = 0;
  endtask

  task automatic rx_quality(input logic [7:0] q);
    @(negedge clk); rx_lqi_valid = 1; rx_lqi = q;
    @(negedge clk); rx_lqi_valid = 0;
  endtask

  // R1
  task automatic t_reset();
    @(negedge clk);
    check(underrun_irq === 1'b0, "R1 underrun_irq", int'(underrun_irq), 0);
    check(host_rvalid === 1'b0, "R1 host_rvalid", int'(host_rvalid), 0);
    check(tx_rvalid === 1'b0, "R1 tx_rvalid", int'(tx_rvalid), 0);
    check(rx_frame_len === 8'd0, "R1 rx_frame_len", int'(rx_frame_len), 0);
  endtask

  // R2, R11
  task automatic t_single();
    logic [7:0] rd; logic rv;
    hwrite(7'd5, 8'hA5);
    hwrite(7'd77, 8'h3C);
    hread_chk(7'd5, 8'hA5, "R2 single addr 5");
    hread_chk(7'd77, 8'h3C, "R2 single addr 77");
    host_op(1'b1, 1'b0, 1'b0, 7'd9, 8'h10, rd, rv);
    check(rv === 1'b0, "R11 no rvalid after write", int'(rv), 0);
  endtask

  // R3: burst from 125 wraps through 127 to 0
  task automatic t_burst();
    logic [7:0] rd; logic rv;
    host_op(1'b1, 1'b1, 1'b1, 7'd125, 8'hC0, rd, rv);
    for (int i = 1; i < 6; i++) begin
      host_op(1'b1, 1'b1, 1'b0, 7'd0, 8'hC0 + 8'(i), rd, rv);
    end
    hread_chk(7'd127, 8'hC2, "R3 burst addr 127");
    hread_chk(7'd0, 8'hC3, "R3 burst wrap addr 0");
    hread_chk(7'd2, 8'hC5, "R3 burst addr 2");
    host_op(1'b0, 1'b1, 1'b1, 7'd126, 8'h00, rd, rv);
    check(rd === 8'hC1, "R3 burst read start 126", int'(rd), 8'hC1);
    host_op(1'b0, 1'b1, 1'b0, 7'd55, 8'h00, rd, rv);
    check(rd === 8'hC2, "R3 burst read 127", int'(rd), 8'hC2);
    host_op(1'b0, 1'b1, 1'b0, 7'd55, 8'h00, rd, rv);
    check(rd === 8'hC3, "R3 burst read wrap 0", int'(rd), 8'hC3);
  endtask

  // R4, R9, R10
  task automatic t_tx();
    logic [7:0] rd; logic rv; logic [7:0] d;
    host_op(1'b1, 1'b1, 1'b1, 7'd0, 8'd4, rd, rv);
    for (int i = 1; i <= 4; i++) begin
      host_op(1'b1, 1'b1, 1'b0, 7'd0, 8'h10 * 8'(i) + 8'(i), rd, rv);
    end
    for (int i = 1; i <= 4; i++) begin
      tx_read(7'(i), d);
      check(d === 8'h10 * 8'(i) + 8'(i), "R4 tx read data", int'(d), int'(8'h10 * 8'(i) + 8'(i)));
    end
    check(underrun_irq === 1'b0, "R9 no underrun within length", int'(underrun_irq), 0);
    tx_read(7'd5, d);
    check(underrun_irq === 1'b1, "R9 underrun past length", int'(underrun_irq), 1);
    repeat (3) @(negedge clk);
    check(underrun_irq === 1'b1, "R9 underrun sticky", int'(underrun_irq), 1);
    @(negedge clk); irq_clr = 1;
    @(negedge clk); irq_clr = 0;
    check(underrun_irq === 1'b0, "R10 clear", int'(underrun_irq), 0);
    @(negedge clk); irq_clr = 1; tx_rd_req = 1; tx_rd_addr = 7'd6;
    @(negedge clk); irq_clr = 0; tx_rd_req = 0;
    check(underrun_irq === 1'b1, "R10 set wins over clear", int'(underrun_irq), 1);
    @(negedge clk); irq_clr = 1;
    @(negedge clk); irq_clr = 0;
    check(underrun_irq === 1'b0, "R10 clear again", int'(underrun_irq), 0);
  endtask

  // R5, R6
  task automatic t_rx();
    rx_begin(8'd3);
    check(rx_frame_len === 8'd3, "R5 frame length", int'(rx_frame_len), 3);
    rx_push(8'hA1); rx_push(8'hA2); rx_push(8'hA3);
    rx_quality(8'h5E);
    hread_chk(7'd1, 8'hA1, "R5 rx byte 1");
    hread_chk(7'd3, 8'hA3, "R5 rx byte 3");
    hread_chk(7'd4, 8'h5E, "R6 quality at len+1");
    rx_begin(8'd127);
    rx_quality(8'h6B);
    hread_chk(7'd0, 8'h6B, "R6 quality wraps to 0");
    rx_begin(8'd3);
  endtask

  // R7
  task automatic t_protect();
    rx_protect = 1;
    rx_begin(8'd9);
    check(rx_frame_len === 8'd3, "R7 length held", int'(rx_frame_len), 3);
    rx_push(8'hEE);
    rx_quality(8'hDD);
    hread_chk(7'd1, 8'hA1, "R7 rx byte blocked");
    hread_chk(7'd4, 8'h5E, "R7 quality blocked");
    @(negedge clk);
    rx_byte_valid = 1; rx_byte = 8'hEF;
    host_req = 1; host_wr = 1; host_burst = 0; host_addr = 7'd1; host_wdata = 8'h42;
    #1;
    check(host_ready === 1'b1, "R7 host ready while protected", int'(host_ready), 1);
    @(negedge clk);
    rx_byte_valid = 0; host_req = 0; host_wr = 0;
    hread_chk(7'd1, 8'h42, "R7 host write lands");
    rx_protect = 0;
  endtask

  // R8
  task automatic t_conflict();
    rx_begin(8'd2);
    check(rx_frame_len === 8'd2, "R5 new frame length", int'(rx_frame_len), 2);
    @(negedge clk);
    rx_byte_valid = 1; rx_byte = 8'h99;
    host_req = 1; host_wr = 1; host_burst = 0; host_addr = 7'd50; host_wdata = 8'h77;
    #1;
    check(host_ready === 1'b0, "R8 host held on collision", int'(host_ready), 0);
    @(negedge clk);
    rx_byte_valid = 0;
    #1;
    check(host_ready === 1'b1, "R8 host granted next cycle", int'(host_ready), 1);
    @(negedge clk);
    host_req = 0; host_wr = 0;
    hread_chk(7'd50, 8'h77, "R8 held host write");
    hread_chk(7'd1, 8'h99, "R8 radio write");
    @(negedge clk);
    tx_rd_req = 1; tx_rd_addr = 7'd1; host_req = 1; host_wr = 0; host_addr = 7'd50;
    #1;
    check(host_ready === 1'b0, "R8 tx read wins", int'(host_ready), 0);
    @(negedge clk);
    tx_rd_req = 0;
    check(tx_rdata === 8'h99, "R4 tx data on collision", int'(tx_rdata), 8'h99);
    @(negedge clk);
    host_req = 0;
    check(host_rdata === 8'h77, "R8 held host read", int'(host_rdata), 8'h77);
  endtask

  task automatic run_all();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_single();
    t_burst();
    t_tx();
    t_rx();
    t_protect();
    t_conflict();
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule